// File: doc/BRIEF.md
# Network-to-Hardware Address Resolution Cache

This block keeps a small table of resolved address pairs. Each pair is a 32-bit network address and the 48-bit hardware address that belongs to it. A sender queries the table before it sends out a resolution request. When the pair is already known, the stored hardware address comes back at once and the request is not needed.

The block takes four commands: lookup by network address, insert of a newly resolved pair, remove of the entry that holds a given network address, and clear of the whole table. Lookup, insert and remove walk the table one entry per clock, starting at entry 0. The block is busy during the walk. Clear acts at once.

Every command ends with a single-cycle done pulse. The pulse carries a hit flag, the index of the entry involved and, for a lookup hit, the stored hardware address.

Top module: `addr_resolve_cache`

## Requirements
- R1: After reset every entry is unused, and busy, done and hit are 0. A lookup on the fresh table reports a miss.
- R2: A command is taken when cmd_valid is 1 and busy is 0. The cmd_op codes are: 2'b00 lookup, 2'b01 insert, 2'b10 remove, 2'b11 clear.
- R3: A lookup that matches a used entry k pulses done k+1 cycles after the accepting edge. The pulse has hit=1, result_idx=k and result_hw equal to the stored hardware address. A lookup with no match pulses done DEPTH cycles after the accepting edge, with hit=0, result_idx=0 and result_hw=0. Busy never lasts more than DEPTH cycles.
- R4: An insert whose key is not in the table writes the pair into the lowest-index unused entry. On an empty table this is entry 0. The insert reports hit=0 and that index, DEPTH cycles after acceptance.
- R5: An insert whose key matches used entry k overwrites only that entry's hardware address and creates no duplicate. It reports hit=1 and result_idx=k after k+1 cycles.
- R6: An insert into a full table with no matching key replaces entries in round-robin order. The order starts at entry 0 and advances by one for each such replacement.
- R7: A remove that matches entry k clears the entry's used flag and zeroes both of its addresses. It reports hit=1 and result_idx=k after k+1 cycles. Afterwards a lookup of that key misses, a lookup of address 0 misses, and the freed slot is the first to be reused.
- R8: A remove that finds no match reports hit=0 after DEPTH cycles and changes no entry.
- R9: Clear empties every entry and restarts the round-robin order at entry 0. It pulses done with hit=0 on the accepting edge itself, and busy is never set.
- R10: A command presented while busy is 1 is ignored.
- R11: Done lasts one cycle and is never high while busy is 1. Result_hw is 0 in every pulse except a lookup hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | Command code (see R2) |
| cmd_net | input | NET_W | Network address key |
| cmd_hw | input | HW_W | Hardware address for insert |
| busy | output | 1 | Table walk in progress |
| done | output | 1 | Command finished (one-cycle pulse) |
| hit | output | 1 | Key found (lookup, insert, remove) |
| result_hw | output | HW_W | Stored hardware address on lookup hit |
| result_idx | output | IDX_W | Entry matched or written |

## Verification
The accepting edge is the clock edge on which the block takes a command. Each result falls due a fixed number of edges after it. A clear is due on the accepting edge itself. A command that matches entry k is due k+1 edges later. A command that walks the whole table is due DEPTH edges later.

The driver notes the free-running cycle count at the negative edge where it presents a command. From that count and the latency above, it computes the cycle in which done must appear. The monitor samples done at negative edges and checks both the values and that cycle. A pulse that comes early, comes late or was never expected is therefore caught.

// File: rtl/arc_pkg.sv
package arc_pkg;

    typedef enum logic [1:0] {
        OP_LOOKUP = 2'b00,
        OP_INSERT = 2'b01,
        OP_REMOVE = 2'b10,
        OP_CLEAR  = 2'b11
    } op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } st_e;

endpackage

// File: rtl/arc_entry_cmp.sv
module arc_entry_cmp #(
    parameter int NET_W = 32
) (
    input  logic             used,
    input  logic [NET_W-1:0] stored,
    input  logic [NET_W-1:0] key,
    output logic             match
);
    // An unused slot never matches, including a key of zero.
    assign match = used && (stored == key);
endmodule

// File: rtl/arc_free_pick.sv
module arc_free_pick #(
    parameter int DEPTH = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [DEPTH-1:0] used,
    output logic             any_free,
    output logic [IDX_W-1:0] free_idx
);
    always_comb begin
        any_free = 1'b0;
        free_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!used[i]) begin
                any_free = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/arc_victim_ptr.sv
module arc_victim_ptr #(
    parameter int DEPTH = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             step,
    output logic [IDX_W-1:0] ptr
);
    logic [IDX_W-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (restart) begin
            ptr_d = '0;
        end else if (step) begin
            ptr_d = (ptr_q == IDX_W'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptr = ptr_q;
endmodule

// File: rtl/addr_resolve_cache.sv
module addr_resolve_cache
    import arc_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int NET_W = 32,
    parameter int HW_W  = 48,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [NET_W-1:0] cmd_net,
    input  logic [HW_W-1:0]  cmd_hw,
    output logic             busy,
    output logic             done,
    output logic             hit,
    output logic [HW_W-1:0]  result_hw,
    output logic [IDX_W-1:0] result_idx
);

    typedef struct packed {
        logic             used;
        logic [NET_W-1:0] net;
        logic [HW_W-1:0]  hw;
    } entry_t;

    typedef struct packed {
        st_e                     st;
        op_e                     op;
        logic [IDX_W-1:0]        idx;
        logic [NET_W-1:0]        key;
        logic [HW_W-1:0]         val;
        logic                    done;
        logic                    hit;
        logic [HW_W-1:0]         rhw;
        logic [IDX_W-1:0]        ridx;
        entry_t [DEPTH-1:0]      tbl;
    } state_t;

    state_t s_d, s_q;

    logic [DEPTH-1:0] used_vec;
    logic             any_free;
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] victim;
    logic             rr_step;
    logic             rr_restart;
    logic             cur_match;
    entry_t           cur;

    for (genvar g = 0; g < DEPTH; g++) begin : g_used
        assign used_vec[g] = s_q.tbl[g].used;
    end

    assign cur = s_q.tbl[s_q.idx];

    arc_entry_cmp #(.NET_W(NET_W)) u_cmp (
        .used   (cur.used),
        .stored (cur.net),
        .key    (s_q.key),
        .match  (cur_match)
    );

    arc_free_pick #(.DEPTH(DEPTH)) u_free (
        .used     (used_vec),
        .any_free (any_free),
        .free_idx (free_idx)
    );

    arc_victim_ptr #(.DEPTH(DEPTH)) u_victim (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (rr_restart),
        .step    (rr_step),
        .ptr     (victim)
    );

    always_comb begin
        s_d        = s_q;
        s_d.done   = 1'b0;
        s_d.hit    = 1'b0;
        s_d.rhw    = '0;
        s_d.ridx   = '0;
        rr_step    = 1'b0;
        rr_restart = 1'b0;

        unique case (s_q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    if (op_e'(cmd_op) == OP_CLEAR) begin
                        s_d.tbl    = '0;
                        s_d.done   = 1'b1;
                        rr_restart = 1'b1;
                    end else begin
                        s_d.st  = ST_SCAN;
                        s_d.op  = op_e'(cmd_op);
                        s_d.idx = '0;
                        s_d.key = cmd_net;
                        s_d.val = cmd_hw;
                    end
                end
            end
            ST_SCAN: begin
                if (cur_match) begin
                    s_d.st   = ST_IDLE;
                    s_d.done = 1'b1;
                    s_d.hit  = 1'b1;
                    s_d.ridx = s_q.idx;
                    unique case (s_q.op)
                        OP_LOOKUP: s_d.rhw = cur.hw;
                        OP_INSERT: s_d.tbl[s_q.idx].hw = s_q.val;
                        OP_REMOVE: s_d.tbl[s_q.idx] = '0;
                        default:   ;
                    endcase
                end else if (s_q.idx == IDX_W'(DEPTH - 1)) begin
                    s_d.st   = ST_IDLE;
                    s_d.done = 1'b1;
                    if (s_q.op == OP_INSERT) begin
                        if (any_free) begin
                            s_d.tbl[free_idx] = '{used: 1'b1, net: s_q.key, hw: s_q.val};
                            s_d.ridx          = free_idx;
                        end else begin
                            s_d.tbl[victim] = '{used: 1'b1, net: s_q.key, hw: s_q.val};
                            s_d.ridx        = victim;
                            rr_step         = 1'b1;
                        end
                    end
                end else begin
                    s_d.idx = s_q.idx + 1'b1;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy       = (s_q.st == ST_SCAN);
    assign done       = s_q.done;
    assign hit        = s_q.hit;
    assign result_hw  = s_q.rhw;
    assign result_idx = s_q.ridx;

endmodule

// File: rtl/arc_checker.sv
module arc_checker #(
    parameter int DEPTH = 8,
    parameter int HW_W  = 48
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cmd_valid,
    input logic [1:0]      cmd_op,
    input logic            busy,
    input logic            done,
    input logic            hit,
    input logic [HW_W-1:0] result_hw
);
    int busy_run;

    always_ff @(posedge clk) begin
        if (!rst_n || !busy) busy_run <= 0;
        else                 busy_run <= busy_run + 1;
    end

    assert_scan_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_run < DEPTH));

    assert_walk_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && cmd_op != 2'b11) |=> busy);

    assert_clear_now_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && cmd_op == 2'b11) |=> (done && !busy && !hit));

    assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_miss_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !hit) |-> (result_hw == '0));

    assert_busy_ends_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
endmodule

bind addr_resolve_cache arc_checker #(.DEPTH(DEPTH), .HW_W(HW_W)) u_arc_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .busy      (busy),
    .done      (done),
    .hit       (hit),
    .result_hw (result_hw)
);

// File: tb/addr_resolve_cache_test.sv
`timescale 1ns/1ps
module addr_resolve_cache_test;
    localparam int DEPTH = 8;
    localparam logic [1:0] LK = 2'b00, IN = 2'b01, RM = 2'b10, CL = 2'b11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'b00;
    logic [31:0] cmd_net = '0;
    logic [47:0] cmd_hw = '0;
    logic        busy, done, hit;
    logic [47:0] result_hw;
    logic [2:0]  result_idx;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 1'b0;

    typedef struct {
        int    due;
        logic  hit;
        logic [47:0] hw;
        int    idx;
        string tag;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    addr_resolve_cache uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_net(cmd_net), .cmd_hw(cmd_hw), .busy(busy), .done(done),
        .hit(hit), .result_hw(result_hw), .result_idx(result_idx)
    );

    function automatic logic [31:0] key(input int i);
        return 32'hC0A8_0100 + i;
    endfunction
    function automatic logic [47:0] hwa(input int i);
        return 48'h02AB_0000_0000 + 48'(i * 17 + 1);
    endfunction

    // Monitor: pops one expected item for each done pulse.
    always @(negedge clk) begin
        if (rst_n && done) begin
            checks++;
            if (sb.size() == 0) begin
                errors++;
                $display("FAIL R11 unexpected done: hit=%0b idx=%0d, expected no pulse", hit, result_idx);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (cyc != e.due || hit !== e.hit || result_hw !== e.hw || int'(result_idx) != e.idx) begin
                    errors++;
                    $display("FAIL %s: got cyc=%0d hit=%0b hw=%h idx=%0d, expected cyc=%0d hit=%0b hw=%h idx=%0d",
                             e.tag, cyc, hit, result_hw, result_idx, e.due, e.hit, e.hw, e.idx);
                end
            end
        end
    end

    task automatic issue(input logic [1:0] op, input logic [31:0] net, input logic [47:0] hw,
                         input logic eh, input logic [47:0] ehw, input int eidx,
                         input int lat, input string tag);
        exp_t e;
        while (busy) @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_net = net; cmd_hw = hw;
        e.due = cyc + 1 + lat; e.hit = eh; e.hw = ehw; e.idx = eidx; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic check_bit(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0b, expected %0b", tag, act, exp);
        end
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got no finish, expected end of run");
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        check_bit(busy, 1'b0, "R1 busy after reset");
        check_bit(done, 1'b0, "R1 done after reset");
        check_bit(hit,  1'b0, "R1 hit after reset");

        issue(LK, key(1), '0, 1'b0, '0, 0, DEPTH, "R1 lookup on empty table");
        issue(IN, key(1), hwa(1), 1'b0, '0, 0, DEPTH, "R4 first insert to entry 0");
        issue(LK, key(1), '0, 1'b1, hwa(1), 0, 1, "R3 lookup hit entry 0");
        for (int i = 2; i <= 8; i++)
            issue(IN, key(i), hwa(i), 1'b0, '0, i - 1, DEPTH, "R4 fill lowest free");
        issue(LK, key(5), '0, 1'b1, hwa(5), 4, 5, "R3 lookup hit entry 4");
        issue(LK, key(8), '0, 1'b1, hwa(8), 7, 8, "R3 lookup hit last entry");

        issue(IN, key(3), hwa(30), 1'b1, '0, 2, 3, "R5 insert overwrite");
        issue(LK, key(3), '0, 1'b1, hwa(30), 2, 3, "R5 lookup sees new value");

        issue(IN, key(9), hwa(9), 1'b0, '0, 0, DEPTH, "R6 full insert victim 0");
        issue(IN, key(10), hwa(10), 1'b0, '0, 1, DEPTH, "R6 full insert victim 1");
        issue(LK, key(1), '0, 1'b0, '0, 0, DEPTH, "R6 replaced key misses");
        issue(LK, key(9), '0, 1'b1, hwa(9), 0, 1, "R6 new key at entry 0");

        issue(RM, key(4), '0, 1'b1, '0, 3, 4, "R7 remove entry 3");
        issue(LK, key(4), '0, 1'b0, '0, 0, DEPTH, "R7 removed key misses");
        issue(RM, key(4), '0, 1'b0, '0, 0, DEPTH, "R8 remove not found");
        issue(LK, 32'h0, '0, 1'b0, '0, 0, DEPTH, "R7 zero key misses");
        issue(IN, key(11), hwa(11), 1'b0, '0, 3, DEPTH, "R7 freed slot reused");

        // R10: commands during a walk are ignored.
        issue(LK, key(12), '0, 1'b0, '0, 0, DEPTH, "R10 long lookup");
        check_bit(busy, 1'b1, "R10 busy during walk");
        cmd_valid = 1'b1; cmd_op = CL;
        @(negedge clk);
        cmd_op = IN; cmd_net = key(13); cmd_hw = hwa(13);
        @(negedge clk);
        cmd_op = RM; cmd_net = key(9);
        @(negedge clk);
        cmd_valid = 1'b0;
        issue(LK, key(9), '0, 1'b1, hwa(9), 0, 1, "R10 entry survived ignored commands");
        issue(LK, key(13), '0, 1'b0, '0, 0, DEPTH, "R10 ignored insert absent");

        issue(CL, '0, '0, 1'b0, '0, 0, 0, "R9 clear pulses at once");
        check_bit(busy, 1'b0, "R9 clear never busy");
        issue(LK, key(9), '0, 1'b0, '0, 0, DEPTH, "R9 cleared key misses");
        for (int i = 20; i < 28; i++)
            issue(IN, key(i), hwa(i), 1'b0, '0, i - 20, DEPTH, "R9 refill from entry 0");
        issue(IN, key(28), hwa(28), 1'b0, '0, 0, DEPTH, "R9 round-robin restarted");
        issue(CL, '0, '0, 1'b0, '0, 0, 0, "R9 clear back to back A");
        issue(CL, '0, '0, 1'b0, '0, 0, 0, "R9 clear back to back B");
        issue(LK, key(28), '0, 1'b0, '0, 0, DEPTH, "R2 lookup after clears");

        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R11 missing done pulses: got %0d pending, expected 0", sb.size());
        end
        summary();
    end
endmodule